// File: doc/BRIEF.md
# Three-Wire Half-Duplex Radio Link Master

This block is a serial master for a radio transceiver that shares one data wire between both directions. It produces the serial clock, turns the data wire around between driving and listening, and owns two active-low selects. One select frames register traffic and the other frames single-byte transfers to and from the transceiver's data buffer. The serial clock idles low. The slave samples on the rising edge. The master changes its output only while the clock is low.

A host issues one command at a time. It sets the kind, address and write byte, then pulses a start strobe. `busy` stays high from the accepted strobe until the post-transfer gap has elapsed. `done` then pulses for one cycle, and `rdata` holds the byte received by the latest read. Every delay is a count of system clocks derived from the system clock frequency parameter. This covers the serial half period, the lead before the first clock, the hold after the last clock and the gap after deselect.

Top module: `spi3w_radio_master`

## Requirements
- R1: After reset both selects are high, the serial clock is low, the data output enable is low, and `busy`, `done` and `rdata` are zero.
- R2: The serial clock is low when idle. Each bit spends H = CLK_HZ/(2*SCK_HZ) system cycles low and then H cycles high. The driven data bit does not change while the clock is high.
- R3: Kind 2'b00 (register write) asserts the register select for 16 clocks. It drives {1'b0, addr[6:0], wdata[7:0]} MSB first, with the output enable high on every rising edge.
- R4: Kind 2'b01 (register read) asserts the register select for 16 clocks. It drives {1'b1, addr[6:0]} on the first 8 rising edges. It then releases the line and samples 8 input bits MSB first, and `rdata` holds that byte when `done` pulses.
- R5: Kind 2'b10 (buffer write) asserts the buffer select for exactly 8 clocks and drives wdata MSB first, with no address phase.
- R6: Kind 2'b11 (buffer read) asserts the buffer select for exactly 8 clocks. The output enable stays low throughout, and `rdata` receives the 8 sampled bits MSB first.
- R7: For buffer transfers the select falls 4H+H cycles before the first rising edge. This is two full serial periods plus the first low phase.
- R8: For buffer transfers the select stays low for us_to_cycles(FIFO_TAIL_US)+1 cycles after the last falling edge.
- R9: After a buffer transfer the select stays high for us_to_cycles(FIFO_GAP_US)+1 cycles before `busy` falls.
- R10: For register transfers the select falls 2H cycles before the first rising edge and rises H cycles after the last falling edge. It then stays high for us_to_cycles(REG_GAP_US) cycles before `busy` falls.
- R11: At most one select is low at any time. With both selects high, the output enable and the serial clock are low.
- R12: A start strobe while `busy` is high is ignored. The running transfer's bits, timing and single `done` are unchanged, and no further transfer begins.
- R13: `done` is a single-cycle pulse in the cycle `busy` falls. `busy` only rises after an accepted start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start strobe, taken only while idle |
| cmd_kind | input | 2 | 00 reg write, 01 reg read, 10 buffer write, 11 buffer read |
| cmd_addr | input | 7 | Register address |
| cmd_wdata | input | 8 | Byte to write |
| busy | output | 1 | Transfer or post-transfer gap in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte from the latest read |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_sdio_o | output | 1 | Data out to the shared wire |
| spi_sdio_oe | output | 1 | Drive enable for the shared wire |
| spi_sdio_i | input | 1 | Data in from the shared wire |
| reg_csn | output | 1 | Register select, active low |
| fifo_csn | output | 1 | Buffer select, active low |

## Verification
The bench builds the block with CLK_HZ = 8 MHz, SCK_HZ = 1 MHz, REG_GAP_US = 3, FIFO_TAIL_US = 2 and FIFO_GAP_US = 4. That gives a 4-cycle half period, a 24-cycle register gap, a 17-cycle buffer hold and a 33-cycle buffer gap. These short windows let a single run cover all 128 register addresses for writes and reads, and all 256 byte values for buffer writes and reads. Every transfer has its lead, hold, gap and clock-high totals measured against figures the bench derives from the frequencies. Some transfers also receive a second start strobe mid-flight.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;

  typedef enum logic [1:0] {
    CMD_REG_WR  = 2'b00,
    CMD_REG_RD  = 2'b01,
    CMD_FIFO_WR = 2'b10,
    CMD_FIFO_RD = 2'b11
  } cmd_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEAD, ST_LOW, ST_HIGH, ST_TAIL, ST_GAP
  } seq_state_e;

  // System cycles per serial half period, never below one.
  function automatic int unsigned half_period_cycles(longint clk_hz, longint sck_hz);
    longint h;
    h = clk_hz / (2 * sck_hz);
    if (h < 1) h = 1;
    return 32'(h);
  endfunction

  // Microseconds to system cycles, rounded up.
  function automatic int unsigned us_to_cycles(longint clk_hz, longint us);
    longint c;
    c = (clk_hz * us + 64'd999_999) / 64'd1_000_000;
    return 32'(c);
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic is_fifo(cmd_kind_e k);
    return (k == CMD_FIFO_WR) || (k == CMD_FIFO_RD);
  endfunction

  // Clocks in one frame under a select.
  function automatic logic [4:0] frame_bits(cmd_kind_e k);
    return is_fifo(k) ? 5'd8 : 5'd16;
  endfunction

  // Leading clocks during which the master drives the wire.
  function automatic logic [4:0] drive_bits(cmd_kind_e k);
    case (k)
      CMD_REG_WR:  return 5'd16;
      CMD_REG_RD:  return 5'd8;
      CMD_FIFO_WR: return 5'd8;
      default:     return 5'd0;
    endcase
  endfunction

  // Outgoing word, MSB first; the read flag sits in the top address bit.
  function automatic logic [15:0] tx_word(cmd_kind_e k, logic [6:0] a, logic [7:0] d);
    case (k)
      CMD_REG_WR:  return {1'b0, a, d};
      CMD_REG_RD:  return {1'b1, a, 8'h00};
      CMD_FIFO_WR: return {d, 8'h00};
      default:     return 16'h0000;
    endcase
  endfunction

endpackage

// File: rtl/spi3w_downcount.sv
module spi3w_downcount #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/spi3w_bitpath.sv
module spi3w_bitpath #(
  parameter int TXW = 16,
  parameter int RXW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [TXW-1:0] load_word,
  input  logic           shift,
  input  logic           sample,
  input  logic           sdi,
  output logic           sdo,
  output logic [RXW-1:0] rx_word
);
  logic [TXW-1:0] tx_sr;
  logic [RXW-1:0] rx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      rx_sr <= '0;
    end else begin
      if (load)       tx_sr <= load_word;
      else if (shift) tx_sr <= {tx_sr[TXW-2:0], 1'b0};
      if (load)        rx_sr <= '0;
      else if (sample) rx_sr <= {rx_sr[RXW-2:0], sdi};
    end
  end

  assign sdo     = tx_sr[TXW-1];
  assign rx_word = rx_sr;
endmodule

// File: rtl/spi3w_radio_master.sv
module spi3w_radio_master
  import spi3w_pkg::*;
#(
  parameter longint CLK_HZ       = 50_000_000,
  parameter longint SCK_HZ       = 1_000_000,
  parameter longint REG_GAP_US   = 100,
  parameter longint FIFO_TAIL_US = 2,
  parameter longint FIFO_GAP_US  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_start,
  input  logic [1:0] cmd_kind,
  input  logic [6:0] cmd_addr,
  input  logic [7:0] cmd_wdata,
  output logic       busy,
  output logic       done,
  output logic [7:0] rdata,
  output logic       spi_sck,
  output logic       spi_sdio_o,
  output logic       spi_sdio_oe,
  input  logic       spi_sdio_i,
  output logic       reg_csn,
  output logic       fifo_csn
);
  localparam int unsigned HALF      = half_period_cycles(CLK_HZ, SCK_HZ);
  localparam int unsigned REG_LEAD  = HALF;
  localparam int unsigned REG_TAIL  = HALF;
  localparam int unsigned REG_GAP   = max2(us_to_cycles(CLK_HZ, REG_GAP_US), 1);
  localparam int unsigned FIFO_LEAD = 4 * HALF;
  localparam int unsigned FIFO_TAIL = us_to_cycles(CLK_HZ, FIFO_TAIL_US) + 1;
  localparam int unsigned FIFO_GAP  = us_to_cycles(CLK_HZ, FIFO_GAP_US) + 1;
  localparam int unsigned MAXD      = max2(max2(REG_GAP, FIFO_GAP),
                                           max2(max2(FIFO_LEAD, FIFO_TAIL), HALF));
  localparam int          TW        = $clog2(MAXD + 1);

  seq_state_e state_q;
  cmd_kind_e  kind_q;
  cmd_kind_e  kind_in;
  logic [4:0] bit_q, nbits_q, ndrive_q;
  logic       sck_q, oe_q, rcsn_q, fcsn_q, done_q;
  logic [7:0] rdata_q;
  logic [7:0] rx_byte;
  logic       sdo;

  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;

  // Named events, shared with the bound checker.
  logic ev_accept, ev_rise, ev_fall, ev_last, ev_end;
  logic fifo_q;

  assign kind_in   = cmd_kind_e'(cmd_kind);
  assign fifo_q    = is_fifo(kind_q);
  assign ev_accept = cmd_start && (state_q == ST_IDLE);
  assign ev_rise   = (state_q == ST_LOW)  && tmr_zero;
  assign ev_fall   = (state_q == ST_HIGH) && tmr_zero;
  assign ev_last   = (bit_q == nbits_q - 5'd1);
  assign ev_end    = (state_q == ST_GAP)  && tmr_zero;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: if (ev_accept) begin
        tmr_load = 1'b1;
        tmr_val  = is_fifo(kind_in) ? TW'(FIFO_LEAD - 1) : TW'(REG_LEAD - 1);
      end
      ST_LEAD, ST_LOW: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = TW'(HALF - 1);
      end
      ST_HIGH: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (ev_last) tmr_val = fifo_q ? TW'(FIFO_TAIL - 1) : TW'(REG_TAIL - 1);
        else         tmr_val = TW'(HALF - 1);
      end
      ST_TAIL: if (tmr_zero) begin
        tmr_load = 1'b1;
        tmr_val  = fifo_q ? TW'(FIFO_GAP - 1) : TW'(REG_GAP - 1);
      end
      default: ;
    endcase
  end

  spi3w_downcount #(.W(TW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  spi3w_bitpath #(.TXW(16), .RXW(8)) u_bits (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_accept),
    .load_word (tx_word(kind_in, cmd_addr, cmd_wdata)),
    .shift     (ev_fall && !ev_last),
    .sample    (ev_rise && (bit_q >= ndrive_q)),
    .sdi       (spi_sdio_i),
    .sdo       (sdo),
    .rx_word   (rx_byte)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      kind_q   <= CMD_REG_WR;
      bit_q    <= '0;
      nbits_q  <= 5'd16;
      ndrive_q <= '0;
      sck_q    <= 1'b0;
      oe_q     <= 1'b0;
      rcsn_q   <= 1'b1;
      fcsn_q   <= 1'b1;
      done_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (ev_accept) begin
          state_q  <= ST_LEAD;
          kind_q   <= kind_in;
          nbits_q  <= frame_bits(kind_in);
          ndrive_q <= drive_bits(kind_in);
          bit_q    <= '0;
          oe_q     <= (drive_bits(kind_in) != 5'd0);
          rcsn_q   <= is_fifo(kind_in);
          fcsn_q   <= !is_fifo(kind_in);
        end
        ST_LEAD: if (tmr_zero) state_q <= ST_LOW;
        ST_LOW: if (tmr_zero) begin
          state_q <= ST_HIGH;
          sck_q   <= 1'b1;
        end
        ST_HIGH: if (tmr_zero) begin
          sck_q <= 1'b0;
          if (bit_q + 5'd1 == ndrive_q) oe_q <= 1'b0;
          if (ev_last) state_q <= ST_TAIL;
          else begin
            state_q <= ST_LOW;
            bit_q   <= bit_q + 5'd1;
          end
        end
        ST_TAIL: if (tmr_zero) begin
          state_q <= ST_GAP;
          rcsn_q  <= 1'b1;
          fcsn_q  <= 1'b1;
          oe_q    <= 1'b0;
        end
        ST_GAP: if (tmr_zero) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
          if (ndrive_q < nbits_q) rdata_q <= rx_byte;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign rdata       = rdata_q;
  assign spi_sck     = sck_q;
  assign spi_sdio_o  = sdo;
  assign spi_sdio_oe = oe_q;
  assign reg_csn     = rcsn_q;
  assign fifo_csn    = fcsn_q;
endmodule

// File: rtl/spi3w_checker.sv
module spi3w_checker (
  input logic clk,
  input logic rst_n,
  input logic cmd_start,
  input logic busy,
  input logic done,
  input logic sck,
  input logic sdo,
  input logic oe,
  input logic rcsn,
  input logic fcsn,
  input logic ev_accept,
  input logic ev_rise,
  input logic ev_fall
);
  p_one_select_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rcsn && !fcsn));

  p_quiet_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rcsn && fcsn) |-> (!oe && !sck));

  p_hold_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sck && $past(sck)) |-> ($stable(sdo) && $stable(oe)));

  p_rise_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rise |=> sck);

  p_fall_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fall |=> !sck);

  p_clock_selected_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> (!rcsn || !fcsn));

  p_done_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_at_fall_r13: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_rise_needs_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_start));

  p_accept_starts_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> busy);
endmodule

bind spi3w_radio_master spi3w_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_start (cmd_start),
  .busy      (busy),
  .done      (done),
  .sck       (spi_sck),
  .sdo       (spi_sdio_o),
  .oe        (spi_sdio_oe),
  .rcsn      (reg_csn),
  .fcsn      (fifo_csn),
  .ev_accept (ev_accept),
  .ev_rise   (ev_rise),
  .ev_fall   (ev_fall)
);

// File: tb/sim_spi3w_radio_master.sv
`timescale 1ns/1ps
module sim_spi3w_radio_master;
  localparam longint CLK = 8_000_000;
  localparam longint SCK = 1_000_000;
  localparam int H  = int'(CLK / (2 * SCK));   // 4
  localparam int US = int'(CLK / 1_000_000);   // 8 cycles per microsecond

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 1'b0;
  logic [1:0] cmd_kind = 2'b00;
  logic [6:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic busy, done, spi_sck, spi_sdio_o, spi_sdio_oe, reg_csn, fifo_csn;
  logic [7:0] rdata;
  logic spi_sdio_i = 1'b0;

  always #4 clk = ~clk;

  spi3w_radio_master #(
    .CLK_HZ(CLK), .SCK_HZ(SCK), .REG_GAP_US(3), .FIFO_TAIL_US(2), .FIFO_GAP_US(4)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_kind(cmd_kind),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .rdata(rdata), .spi_sck(spi_sck), .spi_sdio_o(spi_sdio_o),
    .spi_sdio_oe(spi_sdio_oe), .spi_sdio_i(spi_sdio_i),
    .reg_csn(reg_csn), .fifo_csn(fifo_csn)
  );

  int n_checks = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Slave model and line monitor, sampling on the falling system clock edge.
  int lead_c, tail_c, gap_c, cslow_c, hi_c, n_rise, n_tx, rx_bits;
  int done_c = 0, csfall_c = 0, viol_overlap = 0, viol_idle = 0, viol_mode0 = 0, viol_busy = 0;
  bit sel_reg, sel_fifo, seen_rise, p_sck, p_cs, p_sdo;
  logic [15:0] tx_cap;
  logic [7:0] cur_resp = 8'h00, last_rdata = 8'h00;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_sck = 0; p_cs = 0; p_sdo = 0;
    end else begin
      bit cs;
      cs = !reg_csn || !fifo_csn;
      if (!reg_csn && !fifo_csn) viol_overlap++;
      if (!cs && (spi_sdio_oe || spi_sck)) viol_idle++;
      if (cs && !p_cs) begin
        csfall_c++;
        lead_c = 0; tail_c = 0; gap_c = 0; cslow_c = 0; hi_c = 0;
        n_rise = 0; n_tx = 0; rx_bits = 0; seen_rise = 0; tx_cap = '0;
        sel_reg = !reg_csn; sel_fifo = !fifo_csn;
        spi_sdio_i = cur_resp[7];
      end
      if (cs) cslow_c++;
      if (spi_sck && p_sck && spi_sdio_oe && (spi_sdio_o != p_sdo)) viol_mode0++;
      if (cs && !seen_rise && !spi_sck) lead_c++;
      if (spi_sck) hi_c++;
      if (spi_sck && !p_sck) begin
        seen_rise = 1; n_rise++;
        if (spi_sdio_oe) begin tx_cap = {tx_cap[14:0], spi_sdio_o}; n_tx++; end
        else rx_bits++;
      end
      if (!spi_sck && p_sck) begin
        tail_c = 1;
        if (rx_bits < 8) spi_sdio_i = cur_resp[7 - rx_bits];
      end else if (cs && seen_rise && !spi_sck) tail_c++;
      if (!cs && busy) gap_c++;
      if (done) begin done_c++; last_rdata = rdata; if (busy) viol_busy++; end
      p_sck = spi_sck; p_cs = cs; p_sdo = spi_sdio_o;
    end
  end

  task automatic run(input logic [1:0] k, input logic [6:0] a, input logic [7:0] d,
                     input logic [7:0] r, input bit interfere);
    int d0, f0, nb, ntx, lead, tail, gap;
    bit fifo;
    fifo = k[1];
    nb   = fifo ? 8 : 16;
    ntx  = (k == 2'b00) ? 16 : (k == 2'b11) ? 0 : 8;
    lead = fifo ? 4 * H : H;
    tail = fifo ? 2 * US + 1 : H;
    gap  = fifo ? 4 * US + 1 : 3 * US;
    @(negedge clk);
    cur_resp = r; cmd_kind = k; cmd_addr = a; cmd_wdata = d; cmd_start = 1'b1;
    d0 = done_c; f0 = csfall_c;
    @(negedge clk);
    cmd_start = 1'b0;
    if (interfere) begin
      repeat (30) @(negedge clk);
      cmd_kind = ~k; cmd_addr = ~a; cmd_wdata = ~d; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
    end
    while (done_c == d0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(sel_reg == !fifo && sel_fifo == fifo, "R3/R5 select choice", sel_fifo, fifo);
    check(n_rise == nb, "R5 clock count", n_rise, nb);
    check(n_tx == ntx, "R4 driven bit count", n_tx, ntx);
    case (k)
      2'b00: check(tx_cap == {1'b0, a, d}, "R3 write frame", tx_cap, {1'b0, a, d});
      2'b01: check(tx_cap[7:0] == {1'b1, a}, "R4 read command", tx_cap[7:0], {1'b1, a});
      2'b10: check(tx_cap[7:0] == d, "R5 buffer byte", tx_cap[7:0], d);
      default: ;
    endcase
    if (k[0]) check(last_rdata == r, k[1] ? "R6 buffer read data" : "R4 register read data",
                    last_rdata, r);
    check(lead_c == lead + H, fifo ? "R7 lead" : "R10 lead", lead_c, lead + H);
    check(tail_c == tail, fifo ? "R8 hold" : "R10 hold", tail_c, tail);
    check(gap_c == gap, fifo ? "R9 gap" : "R10 gap", gap_c, gap);
    check(cslow_c == lead + 2 * nb * H + tail, "R2 select low span", cslow_c, lead + 2 * nb * H + tail);
    check(hi_c == nb * H, "R2 clock high total", hi_c, nb * H);
    check(done_c == d0 + 1, "R13 one done per command", done_c, d0 + 1);
    if (interfere) begin
      check(csfall_c == f0 + 1, "R12 no extra transfer", csfall_c, f0 + 1);
      check(busy == 1'b0, "R12 idle after ignored start", busy, 0);
    end
  endtask

  initial begin
    repeat (195_000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(reg_csn && fifo_csn, "R1 selects high in reset", {reg_csn, fifo_csn}, 3);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(reg_csn && fifo_csn, "R1 selects high", {reg_csn, fifo_csn}, 3);
    check(!spi_sck && !spi_sdio_oe, "R1 clock and enable low", {spi_sck, spi_sdio_oe}, 0);
    check(!busy && !done, "R1 busy and done low", {busy, done}, 0);
    check(rdata == 8'h00, "R1 rdata zero", rdata, 0);

    for (int a = 0; a < 128; a++) run(2'b00, 7'(a), 8'(a * 37 + 5), 8'h00, (a % 32) == 7);
    for (int a = 0; a < 128; a++) run(2'b01, 7'(a), 8'h00, 8'(a * 73 + 11), (a % 32) == 9);
    for (int v = 0; v < 256; v++) run(2'b10, 7'h00, 8'(v), 8'h00, (v % 64) == 3);
    for (int v = 0; v < 256; v++) run(2'b11, 7'h00, 8'h00, 8'(v), (v % 64) == 5);

    check(viol_overlap == 0, "R11 selects never both low", viol_overlap, 0);
    check(viol_idle == 0, "R11 quiet while deselected", viol_idle, 0);
    check(viol_mode0 == 0, "R2 data steady while clock high", viol_mode0, 0);
    check(viol_busy == 0, "R13 done with busy low", viol_busy, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule